// File: doc/BRIEF.md
# AES Word-Swap Data Buffer

This block connects a 32-bit register port to a 128-bit cipher core. On the way in, it collects four 32-bit data writes into one 128-bit block. Each word is reordered by a selectable swap mode before it is stored. The block then holds the result until the core takes it. On the way out, it captures one 128-bit result from the core and hands it back as four 32-bit reads, with the same swap applied to each word.

Key and initialization-vector words travel on their own path into two 128-bit registers and are never reordered. Because every swap undoes itself, a single swap function in a shared package serves both directions.

Two counters track progress. `block_full` tells the core that a complete block is waiting, and `out_avail` tells the port that result words can be read. Any write that arrives while a block is waiting is dropped and sets a sticky error flag. The swap mode can only change while both directions are idle.

Top module: `aes_swap_buffer`

## Requirements
- R1: With mode 2'b00, each data word is stored unchanged.
- R2: With mode 2'b01, the two 16-bit halves of each data word are exchanged, so 32'h12345678 is stored as 32'h56781234.
- R3: With mode 2'b10, the four bytes of each data word are reversed, so 32'h12345678 is stored as 32'h78563412.
- R4: With mode 2'b11, all 32 bits of each data word are reversed (bit 31 goes to bit 0), so 32'h12345678 is stored as 32'h1E6A2C48.
- R5: Successive data writes fill `core_block` from the top down: the first write fills bits 127:96 and the fourth fills bits 31:0. A stored word is visible one cycle after its write.
- R6: After reset, `block_full`, `out_avail` and `wr_err` are low and the mode is 2'b00. `block_full` rises one cycle after the fourth write. It falls one cycle after a `core_start` that arrives while it is high.
- R7: A data write that arrives while `block_full` is high leaves `core_block` unchanged and sets `wr_err` one cycle later. `wr_err` stays set until reset.
- R8: When `result_valid` arrives while `out_avail` is low, the result is captured and `out_avail` rises one cycle later. `dout` then shows swapped result bits 127:96, and each `dout_rd` advances to the next lower word. `out_avail` falls after the fourth read. While `out_avail` is low, `dout` is zero and `dout_rd` is ignored. A `result_valid` that arrives while `out_avail` is high is ignored.
- R9: A `kiv_wr` with `kiv_idx` from 0 to 3 writes key word `kiv_idx`, and index 0 maps to `core_key` bits 127:96. Indices 4 to 7 write the same positions of `core_iv`. These words are never swapped.
- R10: A mode write takes effect one cycle later, but only if no data words are pending, `block_full` is low and `out_avail` is low. Otherwise it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Mode write strobe |
| mode_in | input | 2 | New swap mode |
| cur_mode | output | 2 | Active swap mode |
| din_wr | input | 1 | Data word write strobe |
| din | input | 32 | Data word from the port |
| block_full | output | 1 | Complete block is waiting for the core |
| wr_err | output | 1 | Sticky flag: a write arrived while full |
| core_block | output | 128 | Assembled, swapped input block |
| core_start | input | 1 | Core accepts the waiting block |
| result_valid | input | 1 | Core presents a result |
| result_in | input | 128 | Result block from the core |
| dout_rd | input | 1 | Read strobe for the current output word |
| dout | output | 32 | Current swapped output word |
| out_avail | output | 1 | Output words are available |
| kiv_wr | input | 1 | Key or IV word write strobe |
| kiv_idx | input | 3 | 0 to 3 selects a key word, 4 to 7 selects an IV word |
| kiv_data | input | 32 | Key or IV word |
| core_key | output | 128 | Key to the core |
| core_iv | output | 128 | Initialization vector to the core |

## Verification
Every registered result is due exactly one clock after the edge that samples its stimulus. This covers a stored data word, the rise or fall of `block_full`, `wr_err`, a captured result with its `out_avail`, a key or IV word, and a mode change. `dout` follows combinationally from the read pointer, so it moves in that same cycle after a read. The bench drives inputs shortly after the falling edge. Its behavioural model advances on the rising edge, and every output is compared with the model on the next falling edge, half a period after the edge on which the result is due. Directed sequences for each mode, for writes while full and for mode writes at busy times are followed by a long random stretch, and the same per-cycle comparison runs throughout.

// File: rtl/aes_swap_pkg.sv
package aes_swap_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        SWAP_NONE = 2'b00,
        SWAP_HALF = 2'b01,
        SWAP_BYTE = 2'b10,
        SWAP_BIT  = 2'b11
    } swap_mode_e;

    // Every mode is an involution, so this serves input and output.
    function automatic logic [WORD_W-1:0] word_swap(swap_mode_e m, logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] r;
        r = w;
        case (m)
            SWAP_NONE: r = w;
            SWAP_HALF: r = {w[WORD_W/2-1:0], w[WORD_W-1:WORD_W/2]};
            SWAP_BYTE: begin
                for (int b = 0; b < WORD_W/8; b++)
                    r[8*b +: 8] = w[8*(WORD_W/8-1-b) +: 8];
            end
            SWAP_BIT: begin
                for (int i = 0; i < WORD_W; i++)
                    r[i] = w[WORD_W-1-i];
            end
            default: r = w;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/aes_in_gather.sv
module aes_in_gather
    import aes_swap_pkg::*;
#(
    parameter int WORDS = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  swap_mode_e              mode,
    input  logic                    wr,
    input  logic [WORD_W-1:0]       data,
    input  logic                    start,
    output logic [WORDS*WORD_W-1:0] block,
    output logic                    full,
    output logic                    err,
    output logic                    idle
);
    localparam int CNT_W = (WORDS > 1) ? $clog2(WORDS) : 1;

    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] swapped;

    assign swapped = word_swap(mode, data);
    assign idle    = (cnt_q == '0) && !full;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            full  <= 1'b0;
            err   <= 1'b0;
            block <= '0;
        end else begin
            if (wr && full) begin
                err <= 1'b1;
            end else if (wr) begin
                for (int s = 0; s < WORDS; s++) begin
                    if (cnt_q == CNT_W'(s))
                        block[(WORDS-1-s)*WORD_W +: WORD_W] <= swapped;
                end
                if (cnt_q == CNT_W'(WORDS-1)) begin
                    cnt_q <= '0;
                    full  <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
            if (start && full)
                full <= 1'b0;
        end
    end
endmodule

// File: rtl/aes_out_drain.sv
module aes_out_drain
    import aes_swap_pkg::*;
#(
    parameter int WORDS = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  swap_mode_e              mode,
    input  logic                    res_valid,
    input  logic [WORDS*WORD_W-1:0] res,
    input  logic                    rd,
    output logic [WORD_W-1:0]       dout,
    output logic                    avail,
    output logic                    idle
);
    localparam int CNT_W = (WORDS > 1) ? $clog2(WORDS) : 1;

    logic [CNT_W-1:0]          cnt_q;
    logic [WORDS*WORD_W-1:0]   res_q;
    logic [WORD_W-1:0]         cur_word;

    always_comb begin
        cur_word = '0;
        for (int s = 0; s < WORDS; s++) begin
            if (cnt_q == CNT_W'(s))
                cur_word = res_q[(WORDS-1-s)*WORD_W +: WORD_W];
        end
    end

    assign dout = avail ? word_swap(mode, cur_word) : '0;
    assign idle = (cnt_q == '0) && !avail;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            avail <= 1'b0;
            res_q <= '0;
        end else if (avail) begin
            if (rd) begin
                if (cnt_q == CNT_W'(WORDS-1)) begin
                    cnt_q <= '0;
                    avail <= 1'b0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end else if (res_valid) begin
            res_q <= res;
            cnt_q <= '0;
            avail <= 1'b1;
        end
    end
endmodule

// File: rtl/aes_kiv_bank.sv
module aes_kiv_bank
    import aes_swap_pkg::*;
#(
    parameter int WORDS = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr,
    input  logic [IDX_W-1:0]        idx,
    input  logic [WORD_W-1:0]       data,
    output logic [WORDS*WORD_W-1:0] key,
    output logic [WORDS*WORD_W-1:0] iv
);
    localparam int SLOT_W = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam int IDX_W  = SLOT_W + 1;

    logic [SLOT_W-1:0] slot;
    logic              to_iv;

    assign slot  = idx[SLOT_W-1:0];
    assign to_iv = idx[IDX_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            key <= '0;
            iv  <= '0;
        end else if (wr) begin
            for (int s = 0; s < WORDS; s++) begin
                if (slot == SLOT_W'(s)) begin
                    if (to_iv) iv[(WORDS-1-s)*WORD_W +: WORD_W]  <= data;
                    else       key[(WORDS-1-s)*WORD_W +: WORD_W] <= data;
                end
            end
        end
    end
endmodule

// File: rtl/aes_swap_buffer.sv
module aes_swap_buffer
    import aes_swap_pkg::*;
#(
    parameter int WORDS = 4,
    localparam int BLK_W = WORDS * WORD_W,
    localparam int IDX_W = ((WORDS > 1) ? $clog2(WORDS) : 1) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_wr,
    input  logic [1:0]        mode_in,
    output logic [1:0]        cur_mode,
    input  logic              din_wr,
    input  logic [WORD_W-1:0] din,
    output logic              block_full,
    output logic              wr_err,
    output logic [BLK_W-1:0]  core_block,
    input  logic              core_start,
    input  logic              result_valid,
    input  logic [BLK_W-1:0]  result_in,
    input  logic              dout_rd,
    output logic [WORD_W-1:0] dout,
    output logic              out_avail,
    input  logic              kiv_wr,
    input  logic [IDX_W-1:0]  kiv_idx,
    input  logic [WORD_W-1:0] kiv_data,
    output logic [BLK_W-1:0]  core_key,
    output logic [BLK_W-1:0]  core_iv
);
    swap_mode_e mode_q;
    logic       in_idle;
    logic       out_idle;

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= SWAP_NONE;
        else if (mode_wr && in_idle && out_idle)
            mode_q <= swap_mode_e'(mode_in);
    end

    assign cur_mode = mode_q;

    aes_in_gather #(.WORDS(WORDS)) u_gather (
        .clk   (clk),
        .rst   (rst),
        .mode  (mode_q),
        .wr    (din_wr),
        .data  (din),
        .start (core_start),
        .block (core_block),
        .full  (block_full),
        .err   (wr_err),
        .idle  (in_idle)
    );

    aes_out_drain #(.WORDS(WORDS)) u_drain (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode_q),
        .res_valid (result_valid),
        .res       (result_in),
        .rd        (dout_rd),
        .dout      (dout),
        .avail     (out_avail),
        .idle      (out_idle)
    );

    aes_kiv_bank #(.WORDS(WORDS)) u_kiv (
        .clk  (clk),
        .rst  (rst),
        .wr   (kiv_wr),
        .idx  (kiv_idx),
        .data (kiv_data),
        .key  (core_key),
        .iv   (core_iv)
    );
endmodule

// File: rtl/aes_swap_buffer_chk.sv
module aes_swap_buffer_chk #(
    parameter int BLK_W = 128,
    parameter int WORD_W = 32,
    parameter int IDX_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        cur_mode,
    input logic              din_wr,
    input logic              block_full,
    input logic              wr_err,
    input logic [BLK_W-1:0]  core_block,
    input logic              core_start,
    input logic              dout_rd,
    input logic [WORD_W-1:0] dout,
    input logic              out_avail,
    input logic              kiv_wr,
    input logic [IDX_W-1:0]  kiv_idx,
    input logic [WORD_W-1:0] kiv_data,
    input logic [BLK_W-1:0]  core_key
);
    AST_FULL_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (block_full && core_start) |=> !block_full); // R6

    AST_ERR_ON_FULL_WRITE: assert property (@(posedge clk) disable iff (rst)
        (block_full && din_wr) |=> wr_err); // R7

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        wr_err |=> wr_err); // R7

    AST_BLOCK_HELD: assert property (@(posedge clk) disable iff (rst)
        (block_full && !core_start) |=> $stable(core_block)); // R7

    AST_DOUT_HELD: assert property (@(posedge clk) disable iff (rst)
        (out_avail && !dout_rd) |=> $stable(dout)); // R8

    AST_DOUT_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !out_avail |-> (dout == '0)); // R8

    AST_KEY_DIRECT: assert property (@(posedge clk) disable iff (rst)
        (kiv_wr && kiv_idx == '0) |=> (core_key[BLK_W-1 -: WORD_W] == $past(kiv_data))); // R9

    AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (block_full || out_avail) |=> $stable(cur_mode)); // R10
endmodule

bind aes_swap_buffer aes_swap_buffer_chk #(
    .BLK_W (BLK_W),
    .WORD_W(aes_swap_pkg::WORD_W),
    .IDX_W (IDX_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cur_mode   (cur_mode),
    .din_wr     (din_wr),
    .block_full (block_full),
    .wr_err     (wr_err),
    .core_block (core_block),
    .core_start (core_start),
    .dout_rd    (dout_rd),
    .dout       (dout),
    .out_avail  (out_avail),
    .kiv_wr     (kiv_wr),
    .kiv_idx    (kiv_idx),
    .kiv_data   (kiv_data),
    .core_key   (core_key)
);

// File: tb/tb_aes_swap_buffer.sv
module tb_aes_swap_buffer;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         mode_wr = 0;
    logic [1:0]   mode_in = 0;
    logic [1:0]   cur_mode;
    logic         din_wr = 0;
    logic [31:0]  din = 0;
    logic         block_full, wr_err, out_avail;
    logic [127:0] core_block, core_key, core_iv;
    logic         core_start = 0, result_valid = 0, dout_rd = 0;
    logic [127:0] result_in = 0;
    logic [31:0]  dout;
    logic         kiv_wr = 0;
    logic [2:0]   kiv_idx = 0;
    logic [31:0]  kiv_data = 0;

    int checks = 0;
    int errors = 0;
    bit cmp_en = 0;
    bit done = 0;

    always #5 clk = ~clk;

    aes_swap_buffer dut (.*);

    function automatic logic [31:0] ref_swap(logic [1:0] m, logic [31:0] w);
        case (m)
            2'd1:    return {<<16{w}};
            2'd2:    return {<<8{w}};
            2'd3:    return {<<{w}};
            default: return w;
        endcase
    endfunction

    // behavioural reference model
    logic [1:0]   m_mode;
    logic [127:0] m_block, m_res, m_key, m_iv;
    int           m_wcnt, m_rcnt;
    bit           m_full, m_err, m_avail;

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_block = 0; m_res = 0; m_key = 0; m_iv = 0;
            m_wcnt = 0; m_rcnt = 0; m_full = 0; m_err = 0; m_avail = 0;
        end else begin
            bit   was_full, was_avail, idle;
            logic [1:0] old_mode;
            was_full  = m_full;
            was_avail = m_avail;
            old_mode  = m_mode;
            idle      = (m_wcnt == 0) && !m_full && !m_avail;
            if (din_wr) begin
                if (was_full) m_err = 1;
                else begin
                    m_block[127 - 32*m_wcnt -: 32] = ref_swap(old_mode, din);
                    m_wcnt++;
                    if (m_wcnt == 4) begin m_wcnt = 0; m_full = 1; end
                end
            end
            if (core_start && was_full) m_full = 0;
            if (was_avail) begin
                if (dout_rd) begin
                    m_rcnt++;
                    if (m_rcnt == 4) begin m_rcnt = 0; m_avail = 0; end
                end
            end else if (result_valid) begin
                m_res = result_in; m_rcnt = 0; m_avail = 1;
            end
            if (kiv_wr) begin
                if (kiv_idx[2]) m_iv[127 - 32*kiv_idx[1:0] -: 32] = kiv_data;
                else            m_key[127 - 32*kiv_idx[1:0] -: 32] = kiv_data;
            end
            if (mode_wr && idle) m_mode = mode_in;
        end
    end

    task automatic chk(string tag, string what, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    string mode_tag [4] = '{"R1", "R2", "R3", "R4"};

    always @(negedge clk) begin
        if (cmp_en && !done) begin
            chk("R6", "block_full", 128'(block_full), 128'(m_full));
            chk("R7", "wr_err", 128'(wr_err), 128'(m_err));
            chk("R8", "out_avail", 128'(out_avail), 128'(m_avail));
            chk(mode_tag[m_mode], "core_block R5", core_block, m_block);
            chk("R8", "dout", 128'(dout),
                128'(m_avail ? ref_swap(m_mode, m_res[127 - 32*m_rcnt -: 32]) : 32'h0));
            chk("R9", "core_key", core_key, m_key);
            chk("R9", "core_iv", core_iv, m_iv);
            chk("R10", "cur_mode", 128'(cur_mode), 128'(m_mode));
        end
    end

    task automatic idle_inputs();
        mode_wr = 0; din_wr = 0; core_start = 0; result_valid = 0; dout_rd = 0; kiv_wr = 0;
    endtask

    task automatic step();
        @(negedge clk); #2;
    endtask

    task automatic set_mode(logic [1:0] m);
        mode_wr = 1; mode_in = m; step(); idle_inputs();
    endtask

    task automatic write_word(logic [31:0] w);
        din_wr = 1; din = w; step(); idle_inputs();
    endtask

    task automatic read_all();
        for (int i = 0; i < 4; i++) begin
            dout_rd = 1; step(); idle_inputs();
        end
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(posedge clk); cmp_en = 1;
        repeat (3) @(posedge clk);
        @(negedge clk); #2; rst = 0;
        // R6 reset state
        chk("R6", "reset block_full", 128'(block_full), 128'(0));
        chk("R8", "reset out_avail", 128'(out_avail), 128'(0));
        chk("R10", "reset mode", 128'(cur_mode), 128'(0));

        for (int m = 0; m < 4; m++) begin
            set_mode(2'(m));
            write_word(32'h12345678);
            @(negedge clk);
            case (m)
                0: chk("R1", "word0", 128'(core_block[127:96]), 128'(32'h12345678));
                1: chk("R2", "word0", 128'(core_block[127:96]), 128'(32'h56781234));
                2: chk("R3", "word0", 128'(core_block[127:96]), 128'(32'h78563412));
                default: chk("R4", "word0", 128'(core_block[127:96]), 128'(32'h1E6A2C48));
            endcase
            #2;
            set_mode(2'(3 - m));             // R10 ignored while words pending
            write_word(32'hA5A5_0001 + 32'(m));
            write_word(32'h0F0F_F0F0);
            write_word(32'hDEAD_BEEF);       // R5 fourth word to 31:0
            write_word(32'hFFFF_FFFF);       // R7 write while full
            set_mode(2'(m ^ 1));             // R10 ignored while full
            core_start = 1; step(); idle_inputs();
            result_valid = 1; result_in = {32'h0102_0304, 32'h8000_0001, 32'hCAFE_0000, 32'h0000_FFFF};
            step(); idle_inputs();
            result_valid = 1; result_in = '1; step(); idle_inputs(); // R8 ignored while avail
            read_all();
            dout_rd = 1; step(); idle_inputs();                        // R8 ignored when empty
        end

        for (int k = 0; k < 8; k++) begin
            kiv_wr = 1; kiv_idx = 3'(k); kiv_data = 32'h1357_9BDF ^ 32'(k * 32'h1111);
            step(); idle_inputs();
        end

        rst = 1; step(); rst = 0;
        for (int c = 0; c < 3000; c++) begin
            mode_wr      = ($urandom % 6) == 0;
            mode_in      = 2'($urandom);
            din_wr       = ($urandom % 3) == 0;
            din          = $urandom;
            core_start   = ($urandom % 7) == 0;
            result_valid = ($urandom % 9) == 0;
            result_in    = {$urandom, $urandom, $urandom, $urandom};
            dout_rd      = ($urandom % 3) == 0;
            kiv_wr       = ($urandom % 5) == 0;
            kiv_idx      = 3'($urandom);
            kiv_data     = $urandom;
            step();
        end
        idle_inputs();
        step();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule